// File: doc/BRIEF.md
# Atomic Update Reservation Monitor

This block keeps the single reservation that one processor holds for a load-reserve / store-conditional pair in a coherent system with several bus masters. A load-reserve from the processor records the aligned granule that contains the accessed word. A later store-conditional asks whether that reservation survived. The block answers with a pass or fail bit, and on a pass it raises a store-enable so that the word write may proceed. Every store-conditional clears the reservation, whatever its outcome.

The reservation is treated differently depending on who acts on it. For the owning processor it ignores the address: any store-conditional ends it. For other masters it depends on the address: a snooped write or invalidate ends it only when its address lies inside the reserved granule. The granule size is a power-of-two number of bytes and is set by a parameter. Load data, caches and the coherence protocol itself sit outside this block.

Top module: `resv_monitor`

## Requirements
- R1: After reset there is no reservation. `res_valid` and `st_en` are low, and a store-conditional issued before any load-reserve fails.
- R2: A load-reserve (`req_op`=2'b01) records the granule of `req_addr`. A following aligned store-conditional (`req_op`=2'b10) inside that granule passes: `res_pass`=1 and `st_en`=1.
- R3: Every store-conditional clears the reservation, including one whose address lies in another granule. The next store-conditional then fails.
- R4: A snoop write (`snp_op`=2'b01) or snoop invalidate (`snp_op`=2'b10) whose address falls in the reserved granule cancels the reservation. A snoop to any other granule has no effect.
- R5: When a store-conditional and a snoop that hits the reserved granule arrive in the same cycle, the snoop wins: the store-conditional fails and `st_en` stays low.
- R6: A new load-reserve replaces the existing reservation, and only the new granule can then pass.
- R7: A store-conditional whose address has either of bits [1:0] set (not word aligned) fails and still clears the reservation.
- R8: The result appears one cycle after the store-conditional as a single-cycle `res_valid` pulse, with `res_pass` alongside it. `res_pass` holds its value until the next result. `st_en` is high only together with a passing result.
- R9: Any address inside the granule matches. With the default 16-byte granule, a reservation at 0x100 passes for 0x10C and fails for 0x110.
- R10: A load-reserve that arrives in the same cycle as a snoop to its own granule does not create a reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request strobe |
| req_op | input | 2 | 01 load-reserve, 10 store-conditional, other codes ignored |
| req_addr | input | ADDR_W | Byte address of the request |
| snp_op | input | 2 | 01 foreign write, 10 foreign invalidate, other codes none |
| snp_addr | input | ADDR_W | Byte address of the snooped access |
| res_valid | output | 1 | One-cycle result pulse |
| res_pass | output | 1 | Store-conditional outcome, held until the next result |
| st_en | output | 1 | Permission to perform the conditional store |

## Verification
The bound checker checks several properties on every cycle: that the result pulse follows each store-conditional and only a store-conditional, that `st_en` never appears without a passing result, that `res_pass` stays stable between results, that unaligned or snoop-colliding store-conditionals fail, and that two back-to-back store-conditionals cannot both pass. Other behaviours need an address history to set up, and only the bench's scenarios can show them. These are the replacement of a reservation, granule-boundary matching, cancellation by a snoop on a later cycle, the harmlessness of a snoop to another granule, and suppression of a reservation by a same-cycle snoop.

// File: rtl/resv_pkg.sv
package resv_pkg;
    typedef enum logic [1:0] {
        OP_IDLE      = 2'b00,
        OP_RESERVE   = 2'b01,
        OP_CONDSTORE = 2'b10,
        OP_RSVD      = 2'b11
    } req_op_e;

    typedef enum logic [1:0] {
        SNP_NONE  = 2'b00,
        SNP_WRITE = 2'b01,
        SNP_INVAL = 2'b10,
        SNP_RSVD  = 2'b11
    } snp_op_e;
endpackage

// File: rtl/resv_granule_match.sv
module resv_granule_match #(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 4,
    localparam int TAG_W   = ADDR_W - GRAN_LSB
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [TAG_W-1:0]  ref_tag,
    input  logic              ref_valid,
    output logic [TAG_W-1:0]  addr_tag,
    output logic              hit
);
    logic unused_ofs;
    assign unused_ofs = ^addr[GRAN_LSB-1:0];
    assign addr_tag   = addr[ADDR_W-1:GRAN_LSB];
    assign hit        = ref_valid && (addr_tag == ref_tag);
endmodule

// File: rtl/resv_align_chk.sv
module resv_align_chk #(
    parameter int ADDR_W   = 32,
    parameter int WORD_LSB = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              aligned
);
    generate
        if (WORD_LSB > 0) begin : g_chk
            assign aligned = (addr[WORD_LSB-1:0] == '0);
        end else begin : g_byte
            assign aligned = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int GRANULE_BYTES = 16,
    parameter int WORD_BYTES    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              res_valid,
    output logic              res_pass,
    output logic              st_en
);
    localparam int GRAN_LSB = $clog2(GRANULE_BYTES);
    localparam int WORD_LSB = $clog2(WORD_BYTES);
    localparam int TAG_W    = ADDR_W - GRAN_LSB;
    localparam int N_PORTS  = 2;  // 0: processor, 1: snoop

    typedef struct packed {
        logic             resv_vld;
        logic [TAG_W-1:0] resv_tag;
        logic             res_vld;
        logic             res_pass;
        logic             st_en;
    } state_t;

    state_t st_d, st_q;

    logic [ADDR_W-1:0] port_addr [N_PORTS];
    logic [TAG_W-1:0]  port_tag  [N_PORTS];
    logic              port_hit  [N_PORTS];

    assign port_addr[0] = req_addr;
    assign port_addr[1] = snp_addr;

    genvar gi;
    generate
        for (gi = 0; gi < N_PORTS; gi++) begin : g_match
            resv_granule_match #(
                .ADDR_W  (ADDR_W),
                .GRAN_LSB(GRAN_LSB)
            ) match_i (
                .addr     (port_addr[gi]),
                .ref_tag  (st_q.resv_tag),
                .ref_valid(st_q.resv_vld),
                .addr_tag (port_tag[gi]),
                .hit      (port_hit[gi])
            );
        end
    endgenerate

    logic req_aligned;
    resv_align_chk #(
        .ADDR_W  (ADDR_W),
        .WORD_LSB(WORD_LSB)
    ) align_i (
        .addr   (req_addr),
        .aligned(req_aligned)
    );

    req_op_e op;
    snp_op_e sop;
    logic    snp_active;
    logic    snp_kills_old;
    logic    snp_kills_new;

    always_comb begin
        op            = req_op_e'(req_op);
        sop           = snp_op_e'(snp_op);
        snp_active    = (sop == SNP_WRITE) || (sop == SNP_INVAL);
        snp_kills_old = snp_active && port_hit[1];
        snp_kills_new = snp_active && (port_tag[1] == port_tag[0]);

        st_d          = st_q;
        st_d.res_vld  = 1'b0;
        st_d.st_en    = 1'b0;

        if (snp_kills_old) begin
            st_d.resv_vld = 1'b0;
        end

        if (req_valid) begin
            case (op)
                OP_RESERVE: begin
                    st_d.resv_tag = port_tag[0];
                    st_d.resv_vld = !snp_kills_new;
                end
                OP_CONDSTORE: begin
                    st_d.res_vld  = 1'b1;
                    st_d.res_pass = port_hit[0] && req_aligned && !snp_kills_old;
                    st_d.st_en    = port_hit[0] && req_aligned && !snp_kills_old;
                    st_d.resv_vld = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.res_vld;
    assign res_pass  = st_q.res_pass;
    assign st_en     = st_q.st_en;
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
    parameter int ADDR_W        = 32,
    parameter int GRANULE_BYTES = 16,
    parameter int WORD_BYTES    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        snp_op,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              res_valid,
    input logic              res_pass,
    input logic              st_en
);
    localparam int GL = $clog2(GRANULE_BYTES);
    localparam int WL = $clog2(WORD_BYTES);

    logic is_cs, is_rsv, snp_on, same_gran, misaligned;
    assign is_cs      = req_valid && (req_op == 2'b10);
    assign is_rsv     = req_valid && (req_op == 2'b01);
    assign snp_on     = (snp_op == 2'b01) || (snp_op == 2'b10);
    assign same_gran  = (req_addr[ADDR_W-1:GL] == snp_addr[ADDR_W-1:GL]);
    assign misaligned = (WL > 0) && ((req_addr % WORD_BYTES) != 0);

    logic unused_chk;
    assign unused_chk = ^{req_addr[GL-1:0], snp_addr[GL-1:0]};

    // R8: a result follows every store-conditional, one cycle later
    p_result_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_cs |=> res_valid);
    // R8: no result without a store-conditional
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !is_cs |=> !res_valid);
    // R8: the pass bit holds between results
    p_pass_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_pass));
    // R2: store permission only with a passing result
    p_store_needs_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |-> (res_valid && res_pass));
    // R7: misaligned store-conditional never passes
    p_unaligned_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cs && misaligned) |=> (!res_pass && !st_en));
    // R5: colliding snoop beats the store-conditional
    p_snoop_priority_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cs && snp_on && same_gran) |=> (!res_pass && !st_en));
    // R3: back-to-back store-conditionals cannot both pass
    p_sc_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_cs ##1 (is_cs && !is_rsv) |=> !res_pass);
endmodule

bind resv_monitor resv_monitor_chk #(
    .ADDR_W       (ADDR_W),
    .GRANULE_BYTES(GRANULE_BYTES),
    .WORD_BYTES   (WORD_BYTES)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_op   (req_op),
    .req_addr (req_addr),
    .snp_op   (snp_op),
    .snp_addr (snp_addr),
    .res_valid(res_valid),
    .res_pass (res_pass),
    .st_en    (st_en)
);

// File: tb/resv_monitor_tb_top.sv
module resv_monitor_tb_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    snp_op = 2'b00;
    logic [AW-1:0] snp_addr = '0;
    logic          res_valid, res_pass, st_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit    exp_q [$];
    string tag_q [$];

    always #2.5 clk = ~clk;

    resv_monitor dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .snp_op(snp_op), .snp_addr(snp_addr),
        .res_valid(res_valid), .res_pass(res_pass), .st_en(st_en)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle of stimulus, starting and ending at a falling edge
    task automatic cyc(input bit v, input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [1:0] sop, input logic [AW-1:0] sa);
        req_valid = v; req_op = op; req_addr = a;
        snp_op = sop; snp_addr = sa;
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'b00; snp_op = 2'b00;
    endtask

    task automatic rsv(input logic [AW-1:0] a);
        cyc(1'b1, 2'b01, a, 2'b00, '0);
    endtask

    task automatic cs(input logic [AW-1:0] a, input bit exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        cyc(1'b1, 2'b10, a, 2'b00, '0);
    endtask

    task automatic cs_snp(input logic [AW-1:0] a, input logic [1:0] sop,
                          input logic [AW-1:0] sa, input bit exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        cyc(1'b1, 2'b10, a, sop, sa);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: pops expectations as results appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && res_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected result", 1, 0);
                end else begin
                    bit    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(res_pass == e, {t, " pass"}, int'(res_pass), int'(e));
                    check(st_en == e, {t, " st_en (R8)"}, int'(st_en), int'(e));
                end
            end else if (rst_n) begin
                if (st_en) check(1'b0, "R8 st_en without result", 1, 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R1 reset res_valid", int'(res_valid), 0);
        check(st_en == 1'b0, "R1 reset st_en", int'(st_en), 0);
        rst_n = 1'b1;
        @(negedge clk);

        cs(32'h100, 1'b0, "R1 no reservation after reset");

        rsv(32'h100); cs(32'h100, 1'b1, "R2 basic pass");
        cs(32'h100, 1'b0, "R3 cleared by prior store-conditional");

        rsv(32'h200); cs(32'h300, 1'b0, "R3 other granule fails");
        cs(32'h200, 1'b0, "R3 cleared by mismatched store-conditional");

        rsv(32'h100); cs(32'h10C, 1'b1, "R9 same granule other word");
        rsv(32'h100); cs(32'h110, 1'b0, "R9 next granule");

        rsv(32'h400); cyc(1'b0, 2'b00, '0, 2'b01, 32'h408);
        cs(32'h400, 1'b0, "R4 snoop write cancels");
        rsv(32'h400); cyc(1'b0, 2'b00, '0, 2'b10, 32'h40C);
        cs(32'h400, 1'b0, "R4 snoop invalidate cancels");
        rsv(32'h400); cyc(1'b0, 2'b00, '0, 2'b01, 32'h500);
        cs(32'h400, 1'b1, "R4 snoop other granule ignored");

        rsv(32'h600); cs_snp(32'h600, 2'b01, 32'h604, 1'b0, "R5 snoop wins same cycle");

        rsv(32'h700); rsv(32'h800); cs(32'h700, 1'b0, "R6 old granule replaced");
        rsv(32'h700); rsv(32'h800); cs(32'h800, 1'b1, "R6 new granule passes");

        rsv(32'h900); cs(32'h902, 1'b0, "R7 unaligned fails");
        cs(32'h900, 1'b0, "R7 unaligned still clears");

        cyc(1'b1, 2'b01, 32'hA00, 2'b01, 32'hA04);
        cs(32'hA00, 1'b0, "R10 reserve suppressed by same-cycle snoop");
        cyc(1'b1, 2'b01, 32'hB00, 2'b10, 32'hC00);
        cs(32'hB00, 1'b1, "R10 unrelated snoop leaves reserve");

        drain();
        for (int i = 0; i < 3; i++) begin
            check(res_valid == 1'b0, "R8 pulse ends", int'(res_valid), 0);
            check(res_pass == 1'b1, "R8 pass held", int'(res_pass), 1);
            @(negedge clk);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule